// File: doc/BRIEF.md
# Three-Wire Control Register Receiver

This block receives write-only configuration frames for a mixed-signal front end over a three-wire port: an active-low select, a serial clock and a serial data line. Each frame carries sixteen bits. In send order these are a two-bit operation code, a four-bit register address and a ten-bit data word. The receiver oversamples the three lines in the system clock domain. It shifts in one bit on each rising serial-clock edge seen while select is low. When select returns high, it commits the frame to one of five ten-bit registers.

A pin-level operation-enable input sets how strict the receiver is. When the pin is high, every complete frame is written. When it is low, the receiver writes only frames that carry the one valid operation code. The five registers drive the rest of the chip directly. Two power-control outputs combine register bits with an active-low standby pin. An asynchronous active-low reset returns every register to its default value.

Top module: `ctl_sreg_top`

## Requirements
- R1: After the asynchronous reset, the black-level target register reads 64 (only data bit 6 set) and the other four registers read 0.
- R2: Bits are sent in this order: o0, o1, a0, a1, a2, a3, d0 … d9. Address value {a3,a2,a1,a0} selects the register: 0000 selects mode-A, 1000 selects mode-B, 0100 selects gain, 1100 selects black-level target and 0010 selects test. d0 is the least significant data bit.
- R3: Serial-clock rising edges count as bits only while select is low. Raising select clears the bit count, so edges from separate select-low windows never add up.
- R4: A select-low window with fewer than 16 rising serial-clock edges leaves every register unchanged.
- R5: If more than 16 bits arrive in one window, only the last 16 bits received form the frame.
- R6: While the operation-enable input is high, a complete frame is written whatever its operation code.
- R7: While the operation-enable input is low, a complete frame is written only if o0 = 0 and o1 = 1. Any other code leaves the registers unchanged.
- R8: A complete frame whose address is not one of the five listed leaves every register unchanged.
- R9: A frame takes effect only after select rises. Once all 16 bits have arrived, the registers still hold their old values for as long as select stays low.
- R10: standby_o is high when mode-A bit 9 is set or the standby pin is low.
- R11: out_dis_o is high when mode-A bit 7 is set, mode-A bit 9 is set, or the standby pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset to register defaults |
| sel_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdin | input | 1 | Serial data |
| op_en | input | 1 | High: accept any operation code; low: require o0=0, o1=1 |
| stby_pin_n | input | 1 | Active-low standby pin |
| mode_a | output | 10 | Mode-A register (address 0000) |
| mode_b | output | 10 | Mode-B register (address 1000) |
| gain | output | 10 | Gain register (address 0100) |
| blk_tgt | output | 10 | Black-level target register (address 1100) |
| test_reg | output | 10 | Test register (address 0010) |
| standby_o | output | 1 | Standby request |
| out_dis_o | output | 1 | Converter output disable |

## Verification
Directed frames go to each listed address with distinct data patterns. A wrong bit order or a wrong address map therefore shows up in a specific register. Frames with 15, 16 and 20 clock edges separate the discard path from the commit path and from last-16-bits selection. Split windows and serial clocks sent while select is high show whether the count is cleared. Random frames vary the operation code, the operation-enable pin, the address (listed and unlisted) and the standby pin together. These frames exercise the gating rules against a bench model. A check taken after the sixteenth bit but before select rises tells a commit on select rise apart from an early commit.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    parameter int unsigned FRAME_W = 16;
    parameter int unsigned OP_W    = 2;
    parameter int unsigned ADDR_W  = 4;
    parameter int unsigned DATA_W  = 10;
    parameter int unsigned NREG    = 5;
    localparam int unsigned CNT_W  = $clog2(FRAME_W + 1);

    typedef logic [DATA_W-1:0] word_t;

    localparam int unsigned IDX_MODE_A = 0;
    localparam int unsigned IDX_MODE_B = 1;
    localparam int unsigned IDX_GAIN   = 2;
    localparam int unsigned IDX_BLK    = 3;
    localparam int unsigned IDX_TEST   = 4;

    localparam logic [ADDR_W-1:0] ADR_MODE_A = 4'b0000;
    localparam logic [ADDR_W-1:0] ADR_MODE_B = 4'b1000;
    localparam logic [ADDR_W-1:0] ADR_GAIN   = 4'b0100;
    localparam logic [ADDR_W-1:0] ADR_BLK    = 4'b1100;
    localparam logic [ADDR_W-1:0] ADR_TEST   = 4'b0010;

    localparam word_t BLK_DEFAULT = word_t'(64);
    localparam logic [OP_W-1:0] OP_WRITE = 2'b10;  // op[0]=o0=0, op[1]=o1=1

    localparam int unsigned STBY_BIT = 9;
    localparam int unsigned ODIS_BIT = 7;

    typedef struct packed {
        logic              valid;
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] addr;
        word_t             data;
    } frame_t;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [W-1:0] stage_d;
        if (s == 0) begin : g_first
            assign stage_d = din;
        end else begin : g_next
            assign stage_d = stage_q[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_d;
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sreg_rx.sv
module sreg_rx
    import sreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n_s,
    input  logic             sclk_s,
    input  logic             sd_s,
    output frame_t           frm,
    output logic             cs_rise,
    output logic [CNT_W-1:0] bit_cnt
);
    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   cnt;
        logic               sclk_prev;
        logic               sel_prev;
    } rx_t;

    rx_t s_d, s_q;

    always_comb begin
        s_d           = s_q;
        s_d.sclk_prev = sclk_s;
        s_d.sel_prev  = sel_n_s;
        if (sel_n_s) begin
            s_d.cnt = '0;
        end else if (sclk_s && !s_q.sclk_prev) begin
            s_d.shreg = {s_q.shreg[FRAME_W-2:0], sd_s};
            if (s_q.cnt != CNT_W'(FRAME_W)) s_d.cnt = s_q.cnt + 1'b1;
        end

        cs_rise   = sel_n_s && !s_q.sel_prev;
        frm.valid = cs_rise && (s_q.cnt == CNT_W'(FRAME_W));
        for (int i = 0; i < OP_W; i++)
            frm.op[i] = s_q.shreg[FRAME_W-1-i];
        for (int i = 0; i < ADDR_W; i++)
            frm.addr[i] = s_q.shreg[FRAME_W-1-OP_W-i];
        for (int i = 0; i < DATA_W; i++)
            frm.data[i] = s_q.shreg[DATA_W-1-i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.shreg     <= '0;
            s_q.cnt       <= '0;
            s_q.sclk_prev <= 1'b0;
            s_q.sel_prev  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign bit_cnt = s_q.cnt;
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
    import sreg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  frame_t                  frm,
    input  logic                    op_en,
    output logic [NREG*DATA_W-1:0]  regs_flat
);
    typedef struct packed {
        word_t [NREG-1:0] r;
    } bank_t;

    bank_t b_d, b_q;
    logic  accept;

    always_comb begin
        b_d    = b_q;
        accept = frm.valid && (op_en || (frm.op == OP_WRITE));
        if (accept) begin
            case (frm.addr)
                ADR_MODE_A: b_d.r[IDX_MODE_A] = frm.data;
                ADR_MODE_B: b_d.r[IDX_MODE_B] = frm.data;
                ADR_GAIN:   b_d.r[IDX_GAIN]   = frm.data;
                ADR_BLK:    b_d.r[IDX_BLK]    = frm.data;
                ADR_TEST:   b_d.r[IDX_TEST]   = frm.data;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++)
                b_q.r[i] <= (i == IDX_BLK) ? BLK_DEFAULT : '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign regs_flat = b_q.r;
endmodule

// File: rtl/ctl_sreg_top.sv
module ctl_sreg_top
    import sreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              op_en,
    input  logic              stby_pin_n,
    output logic [DATA_W-1:0] mode_a,
    output logic [DATA_W-1:0] mode_b,
    output logic [DATA_W-1:0] gain,
    output logic [DATA_W-1:0] blk_tgt,
    output logic [DATA_W-1:0] test_reg,
    output logic              standby_o,
    output logic              out_dis_o
);
    logic [2:0]             line_s;
    frame_t                 frm;
    logic                   cs_rise;
    logic [CNT_W-1:0]       bit_cnt;
    logic [NREG*DATA_W-1:0] regs_flat;

    sreg_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sel_n, sclk, sdin}),
        .dout (line_s)
    );

    sreg_rx u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_n_s(line_s[2]),
        .sclk_s (line_s[1]),
        .sd_s   (line_s[0]),
        .frm    (frm),
        .cs_rise(cs_rise),
        .bit_cnt(bit_cnt)
    );

    sreg_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm      (frm),
        .op_en    (op_en),
        .regs_flat(regs_flat)
    );

    assign mode_a   = regs_flat[IDX_MODE_A*DATA_W +: DATA_W];
    assign mode_b   = regs_flat[IDX_MODE_B*DATA_W +: DATA_W];
    assign gain     = regs_flat[IDX_GAIN*DATA_W   +: DATA_W];
    assign blk_tgt  = regs_flat[IDX_BLK*DATA_W    +: DATA_W];
    assign test_reg = regs_flat[IDX_TEST*DATA_W   +: DATA_W];

    assign standby_o = mode_a[STBY_BIT] | ~stby_pin_n;
    assign out_dis_o = mode_a[ODIS_BIT] | standby_o;
endmodule

// File: rtl/sreg_chk.sv
module sreg_chk
    import sreg_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sel_n_s,
    input logic                   cs_rise,
    input logic [CNT_W-1:0]       bit_cnt,
    input logic                   frm_valid,
    input logic [OP_W-1:0]        frm_op,
    input logic                   op_en,
    input logic [NREG*DATA_W-1:0] regs_flat,
    input logic                   stby_pin_n,
    input logic                   standby_o,
    input logic                   out_dis_o
);
    a_r9_commit_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> $stable(regs_flat));

    a_r4_short_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && bit_cnt != CNT_W'(FRAME_W)) |=> $stable(regs_flat));

    a_r3_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |=> (bit_cnt == '0));

    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_W));

    a_r7_op_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !op_en && frm_op != OP_WRITE) |=> $stable(regs_flat));

    a_r11_dis_covers_stby: assert property (@(posedge clk) disable iff (!rst_n)
        standby_o |-> out_dis_o);

    a_r10_pin_standby: assert property (@(posedge clk) disable iff (!rst_n)
        !stby_pin_n |-> (standby_o && out_dis_o));
endmodule

bind ctl_sreg_top sreg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n_s   (line_s[2]),
    .cs_rise   (cs_rise),
    .bit_cnt   (bit_cnt),
    .frm_valid (frm.valid),
    .frm_op    (frm.op),
    .op_en     (op_en),
    .regs_flat (regs_flat),
    .stby_pin_n(stby_pin_n),
    .standby_o (standby_o),
    .out_dis_o (out_dis_o)
);

// File: tb/ctl_sreg_top_bench.sv
module ctl_sreg_top_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, sclk = 1'b0, sdin = 1'b0, op_en = 1'b1, stby_pin_n = 1'b1;
    logic [9:0] mode_a, mode_b, gain, blk_tgt, test_reg;
    logic standby_o, out_dis_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    logic [9:0] exp_r [5];

    always #4 clk = ~clk;

    ctl_sreg_top u_ctl_sreg_top (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdin(sdin),
        .op_en(op_en), .stby_pin_n(stby_pin_n),
        .mode_a(mode_a), .mode_b(mode_b), .gain(gain), .blk_tgt(blk_tgt),
        .test_reg(test_reg), .standby_o(standby_o), .out_dis_o(out_dis_o)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [15:0] mk(input logic [1:0] op, input logic [3:0] adr,
                                       input logic [9:0] dat);
        logic [15:0] f;
        f[15] = op[0]; f[14] = op[1];
        f[13] = adr[0]; f[12] = adr[1]; f[11] = adr[2]; f[10] = adr[3];
        for (int k = 0; k < 10; k++) f[9-k] = dat[k];
        return f;
    endfunction

    function automatic int adr_idx(input logic [3:0] adr);
        case (adr)
            4'b0000: return 0;
            4'b1000: return 1;
            4'b0100: return 2;
            4'b1100: return 3;
            4'b0010: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic void model(input logic [31:0] bits, input int n, input logic oe);
        logic [15:0] f;
        logic [9:0] d;
        int idx;
        if (n < 16) return;
        f = bits[15:0];
        if (!oe && !(f[15] == 1'b0 && f[14] == 1'b1)) return;
        idx = adr_idx({f[10], f[11], f[12], f[13]});
        if (idx < 0) return;
        for (int k = 0; k < 10; k++) d[k] = f[9-k];
        exp_r[idx] = d;
    endfunction

    task automatic chk(input string req, input string what, input logic [9:0] act,
                       input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        logic stb, dis;
        stb = exp_r[0][9] | ~stby_pin_n;
        dis = exp_r[0][7] | exp_r[0][9] | ~stby_pin_n;
        chk(req, "mode_a", mode_a, exp_r[0]);
        chk(req, "mode_b", mode_b, exp_r[1]);
        chk(req, "gain", gain, exp_r[2]);
        chk(req, "blk_tgt", blk_tgt, exp_r[3]);
        chk(req, "test_reg", test_reg, exp_r[4]);
        chk("R10", "standby_o", {9'd0, standby_o}, {9'd0, stb});
        chk("R11", "out_dis_o", {9'd0, out_dis_o}, {9'd0, dis});
    endtask

    task automatic shift_bits(input logic [31:0] bits, input int n);
        sel_n = 1'b0;
        wait_clk(4);
        for (int i = n - 1; i >= 0; i--) begin
            sdin = bits[i];
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
        end
        wait_clk(4);
    endtask

    task automatic release_sel();
        sel_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic send(input logic [31:0] bits, input int n, input logic oe, input string req);
        op_en = oe;
        shift_bits(bits, n);
        release_sel();
        model(bits, n, oe);
        chk_all(req);
    endtask

    initial begin
        #1500000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        exp_r[0] = 0; exp_r[1] = 0; exp_r[2] = 0; exp_r[3] = 10'd64; exp_r[4] = 0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        chk_all("R1");

        // R2: each listed address with a distinct pattern
        send({16'd0, mk(2'b10, 4'b0000, 10'h001)}, 16, 1'b1, "R2");
        send({16'd0, mk(2'b10, 4'b1000, 10'h2A5)}, 16, 1'b1, "R2");
        send({16'd0, mk(2'b10, 4'b0100, 10'h17F)}, 16, 1'b1, "R2");
        send({16'd0, mk(2'b10, 4'b1100, 10'h013)}, 16, 1'b1, "R2");
        send({16'd0, mk(2'b10, 4'b0010, 10'h340)}, 16, 1'b1, "R2");

        // R9: all bits in, select still low
        op_en = 1'b1;
        shift_bits({16'd0, mk(2'b10, 4'b0100, 10'h055)}, 16);
        chk_all("R9");
        release_sel();
        model({16'd0, mk(2'b10, 4'b0100, 10'h055)}, 16, 1'b1);
        chk_all("R9");

        // R4: fifteen edges
        send({17'd0, mk(2'b10, 4'b0100, 10'h3FF) >> 1}, 15, 1'b1, "R4");
        // R5: twenty edges, last sixteen kept
        send({12'd0, 4'b1011, mk(2'b10, 4'b1000, 10'h0F0)}, 20, 1'b1, "R5");
        // R3: two windows of ten bits
        begin
            logic [15:0] f;
            f = mk(2'b10, 4'b0100, 10'h2AA);
            op_en = 1'b1;
            shift_bits({16'd0, 6'd0, f[15:6]}, 10);
            release_sel();
            shift_bits({16'd0, 6'd0, f[9:0]}, 10);
            release_sel();
            chk_all("R3");
            // serial clocks while select is high, then eight bits
            for (int i = 0; i < 8; i++) begin
                sclk = 1'b1; wait_clk(4); sclk = 1'b0; wait_clk(4);
            end
            shift_bits({24'd0, f[7:0]}, 8);
            release_sel();
            chk_all("R3");
        end
        // R6 / R7
        send({16'd0, mk(2'b00, 4'b0010, 10'h111)}, 16, 1'b1, "R6");
        send({16'd0, mk(2'b00, 4'b0010, 10'h222)}, 16, 1'b0, "R7");
        send({16'd0, mk(2'b11, 4'b0010, 10'h233)}, 16, 1'b0, "R7");
        send({16'd0, mk(2'b01, 4'b0010, 10'h244)}, 16, 1'b0, "R7");
        send({16'd0, mk(2'b10, 4'b0010, 10'h255)}, 16, 1'b0, "R7");
        // R8: unlisted addresses
        send({16'd0, mk(2'b10, 4'b0001, 10'h3C3)}, 16, 1'b1, "R8");
        send({16'd0, mk(2'b10, 4'b1111, 10'h3C3)}, 16, 1'b1, "R8");
        // R10 / R11: pin and register bits
        stby_pin_n = 1'b0; wait_clk(1); chk_all("R10");
        stby_pin_n = 1'b1; wait_clk(1); chk_all("R11");
        send({16'd0, mk(2'b10, 4'b0000, 10'h080)}, 16, 1'b1, "R11");
        send({16'd0, mk(2'b10, 4'b0000, 10'h200)}, 16, 1'b1, "R10");
        send({16'd0, mk(2'b10, 4'b0000, 10'h000)}, 16, 1'b1, "R10");

        // random frames
        for (int t = 0; t < 60; t++) begin
            logic [3:0] adr;
            logic [1:0] op;
            int n;
            logic [31:0] bits;
            case ($urandom_range(0, 5))
                0: adr = 4'b0000; 1: adr = 4'b1000; 2: adr = 4'b0100;
                3: adr = 4'b1100; 4: adr = 4'b0010;
                default: adr = 4'($urandom_range(0, 15));
            endcase
            op = ($urandom_range(0, 1) == 1) ? 2'b10 : 2'($urandom_range(0, 3));
            n = $urandom_range(14, 19);
            bits = {$urandom(), 16'd0} | 32'(mk(op, adr, 10'($urandom())));
            if (n < 16) bits = bits >> (16 - n);
            stby_pin_n = ($urandom_range(0, 3) != 0);
            send(bits, n, 1'($urandom_range(0, 1)), "R2");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule